// File: doc/BRIEF.md
# Word-Serial Byte Transfer Commander

This block is a bus-master sequencer that moves single bytes to and from a message-based servant. Every byte costs several register accesses: the engine polls the servant's status word until the right ready bits are set, then writes a command word, and for a receive it polls a second time before it fetches the returned byte from the data word. The local side sees only a send request (byte plus an end-of-message flag) and a receive request, followed by a completion pulse with the outcome.

The bus side is a plain single-access master port. The engine raises a request with address, direction and write data, and holds them until the servant acknowledges or signals an error. Each poll phase is bounded by a programmable count of not-ready reads. A bus error stops the transfer at once. Both aborts are reported through sticky flags.

Top module: `wsc_commander`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o`, `bus_req_o`, `err_timeout_o` and `err_bus_o` are 0.
- R2: In idle, `send_req_i` or `recv_req_i` is accepted at the clock edge and `busy_o` is 1 from the next cycle until the transfer ends. Requests while busy are ignored. When both are high in the same idle cycle, the send is taken and the receive is dropped.
- R3: Once `bus_req_o` is high, it and `bus_addr_o`, `bus_we_o` and `bus_wdata_o` stay unchanged until a cycle in which `bus_ack_i` or `bus_err_i` is high, which ends that access.
- R4: A send first reads offset 0x0A (status) repeatedly until a read returns bit 9 (write ready) and bit 12 (input ready) both set.
- R5: The send then writes one word to offset 0x0E (data): 16'hBC00 OR the byte, or 16'hBD00 OR the byte when the end flag was set. The send ends with this write.
- R6: A receive first reads offset 0x0A until bit 9 (write ready) and bit 13 (output ready) are both set, then writes 16'hDEFF to offset 0x0E.
- R7: A receive then reads 0x0A until bit 10 (read ready) is set, then reads 0x0E. Bits 7:0 of that read appear on `recv_data_o` and bit 8 on `recv_end_o`. Both hold until the next successful receive.
- R8: With limit L on `poll_limit_i` (0 acting as 1), the L-th consecutive not-ready read within one poll phase aborts the transfer, sets `err_timeout_o`, and makes no further bus access.
- R9: An access that ends with `bus_err_i` high aborts the transfer immediately and sets `err_bus_o`. No further access follows.
- R10: `done_o` is a one-cycle pulse in the cycle after the final access of a transfer ends, whether the transfer succeeded or aborted. `busy_o` falls in that same cycle. The error flags hold until the next request is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_req_i | input | 1 | Request to send one byte |
| send_data_i | input | 8 | Byte to send |
| send_end_i | input | 1 | Mark the byte as end of message |
| recv_req_i | input | 1 | Request to receive one byte |
| poll_limit_i | input | CNT_W | Maximum not-ready status reads per poll phase |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (one-cycle pulse) |
| recv_data_o | output | 8 | Last received byte |
| recv_end_o | output | 1 | End flag of the last received byte |
| err_timeout_o | output | 1 | Last transfer aborted by the poll limit |
| err_bus_o | output | 1 | Last transfer aborted by a bus error |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | ADDR_W | Register offset |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data |
| bus_ack_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access failed |

## Verification
Two events can fall on the same clock edge here. One is a send and a receive request arriving together in idle. The other is a new request landing in the very cycle `done_o` pulses, while a late receive request is still held high from an earlier busy period. The bench raises both requests in one cycle and checks that only the send's command word reaches the bus and no 16'hDEFF is written. It also pulses a receive request mid-transfer and checks that no extra bus traffic follows the completion pulse. A behavioural per-cycle model judges every cycle of these runs, with the servant's ready bits and acknowledge latency scripted.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_A,
    ST_CMD,
    ST_POLL_B,
    ST_FETCH
  } wsc_state_e;

  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CMD_BYTE_REQ  = 16'hDEFF;
  localparam logic [7:0]        CMD_AVAIL     = 8'hBC;
  localparam logic [7:0]        CMD_AVAIL_END = 8'hBD;
endpackage

// File: rtl/wsc_poll_counter.sv
module wsc_poll_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             miss_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] eff_limit;
  logic [EXT_W-1:0] next_cnt;

  // a limit of zero behaves as one
  assign eff_limit = (limit_i == '0) ? EXT_W'(1) : {1'b0, limit_i};
  assign next_cnt  = {1'b0, cnt_q} + EXT_W'(1);
  assign expire_o  = miss_i && (next_cnt >= eff_limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (miss_i)   cnt_q <= next_cnt[CNT_W-1:0];
  end

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/wsc_bus_drive.sv
module wsc_bus_drive import wsc_pkg::*; #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] RESP_OFS = 8'h0A,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h0E
) (
  input  wsc_state_e        state_i,
  input  logic              dir_send_i,
  input  logic [7:0]        data_i,
  input  logic              end_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [WORD_W-1:0] avail_word;

  assign avail_word = {(end_i ? CMD_AVAIL_END : CMD_AVAIL), data_i};

  always_comb begin
    req_o   = (state_i != ST_IDLE);
    we_o    = (state_i == ST_CMD);
    addr_o  = (state_i == ST_CMD || state_i == ST_FETCH) ? DATA_OFS : RESP_OFS;
    wdata_o = '0;
    if (state_i == ST_CMD) wdata_o = dir_send_i ? avail_word : CMD_BYTE_REQ;
  end
endmodule

// File: rtl/wsc_seq.sv
module wsc_seq import wsc_pkg::*; #(
  parameter int unsigned WR_BIT  = 9,
  parameter int unsigned RR_BIT  = 10,
  parameter int unsigned DIR_BIT = 12,
  parameter int unsigned DOR_BIT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_req_i,
  input  logic [7:0]        send_data_i,
  input  logic              send_end_i,
  input  logic              recv_req_i,
  input  logic [WORD_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic              expire_i,
  output logic              miss_o,
  output logic              clear_o,
  output wsc_state_e        state_o,
  output logic              dir_send_o,
  output logic [7:0]        data_o,
  output logic              end_o,
  output logic              done_o,
  output logic [7:0]        rx_data_o,
  output logic              rx_end_o,
  output logic              err_timeout_o,
  output logic              err_bus_o
);
  wsc_state_e state_q;
  logic       dir_q, end_q, done_q, to_q, be_q, rx_end_q;
  logic [7:0] data_q, rx_q;
  logic       ok_a, ok_b, poll_st, ready, good_ack;

  assign ok_a     = bus_rdata_i[WR_BIT] &&
                    (dir_q ? bus_rdata_i[DIR_BIT] : bus_rdata_i[DOR_BIT]);
  assign ok_b     = bus_rdata_i[RR_BIT];
  assign poll_st  = (state_q == ST_POLL_A) || (state_q == ST_POLL_B);
  assign ready    = (state_q == ST_POLL_A) ? ok_a : ok_b;
  assign good_ack = bus_ack_i && !bus_err_i;
  assign miss_o   = poll_st && good_ack && !ready;
  assign clear_o  = (state_q == ST_IDLE) || (poll_st && good_ack && ready);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dir_q    <= 1'b0;
      data_q   <= '0;
      end_q    <= 1'b0;
      done_q   <= 1'b0;
      to_q     <= 1'b0;
      be_q     <= 1'b0;
      rx_q     <= '0;
      rx_end_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (send_req_i || recv_req_i) begin
          state_q <= ST_POLL_A;
          dir_q   <= send_req_i;   // send wins a tie
          data_q  <= send_data_i;
          end_q   <= send_end_i;
          to_q    <= 1'b0;
          be_q    <= 1'b0;
        end
      end else if (bus_err_i) begin
        be_q    <= 1'b1;
        done_q  <= 1'b1;
        state_q <= ST_IDLE;
      end else if (bus_ack_i) begin
        case (state_q)
          ST_POLL_A, ST_POLL_B: begin
            if (ready) begin
              state_q <= (state_q == ST_POLL_A) ? ST_CMD : ST_FETCH;
            end else if (expire_i) begin
              to_q    <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_CMD: begin
            if (dir_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_POLL_B;
            end
          end
          ST_FETCH: begin
            rx_q     <= bus_rdata_i[7:0];
            rx_end_q <= bus_rdata_i[8];
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o       = state_q;
  assign dir_send_o    = dir_q;
  assign data_o        = data_q;
  assign end_o         = end_q;
  assign done_o        = done_q;
  assign rx_data_o     = rx_q;
  assign rx_end_o      = rx_end_q;
  assign err_timeout_o = to_q;
  assign err_bus_o     = be_q;

  assert_timeout_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> $past(miss_o && expire_i));

  assert_fetch_after_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) && !$past(state_q == ST_FETCH) |->
      $past(state_q == ST_POLL_B && bus_ack_i && bus_rdata_i[RR_BIT]));
endmodule

// File: rtl/wsc_commander.sv
module wsc_commander import wsc_pkg::*; #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned CNT_W   = 16,
  parameter logic [ADDR_W-1:0] RESP_OFS = 8'h0A,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h0E,
  parameter int unsigned WR_BIT  = 9,
  parameter int unsigned RR_BIT  = 10,
  parameter int unsigned DIR_BIT = 12,
  parameter int unsigned DOR_BIT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_req_i,
  input  logic [7:0]        send_data_i,
  input  logic              send_end_i,
  input  logic              recv_req_i,
  input  logic [CNT_W-1:0]  poll_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        recv_data_o,
  output logic              recv_end_o,
  output logic              err_timeout_o,
  output logic              err_bus_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  input  logic [15:0]       bus_rdata_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i
);
  wsc_state_e state;
  logic       dir_send, end_flag, miss, clear, expire;
  logic [7:0] data;

  wsc_seq #(
    .WR_BIT(WR_BIT), .RR_BIT(RR_BIT), .DIR_BIT(DIR_BIT), .DOR_BIT(DOR_BIT)
  ) u_seq (
    .clk_i, .rst_ni,
    .send_req_i, .send_data_i, .send_end_i, .recv_req_i,
    .bus_rdata_i, .bus_ack_i, .bus_err_i,
    .expire_i(expire), .miss_o(miss), .clear_o(clear),
    .state_o(state), .dir_send_o(dir_send), .data_o(data), .end_o(end_flag),
    .done_o, .rx_data_o(recv_data_o), .rx_end_o(recv_end_o),
    .err_timeout_o, .err_bus_o
  );

  wsc_poll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clear_i(clear), .miss_i(miss), .limit_i(poll_limit_i), .expire_o(expire)
  );

  wsc_bus_drive #(.ADDR_W(ADDR_W), .RESP_OFS(RESP_OFS), .DATA_OFS(DATA_OFS)) u_drv (
    .state_i(state), .dir_send_i(dir_send), .data_i(data), .end_i(end_flag),
    .req_o(bus_req_o), .we_o(bus_we_o), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o)
  );

  assign busy_o = (state != ST_IDLE);

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !bus_err_i |=>
      bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o));

  assert_err_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_err_i |=> !bus_req_o && err_bus_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(bus_req_o));

  assert_cmd_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |->
      bus_addr_o == DATA_OFS &&
      (bus_wdata_o[15:8] == CMD_AVAIL || bus_wdata_o[15:8] == CMD_AVAIL_END ||
       bus_wdata_o == CMD_BYTE_REQ));
endmodule

// File: tb/wsc_commander_tb_top.sv
module wsc_commander_tb_top;
  localparam logic [15:0] B_WR = 16'h0200, B_RR = 16'h0400,
                          B_DIR = 16'h1000, B_DOR = 16'h2000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        send_req_i = 0, send_end_i = 0, recv_req_i = 0;
  logic [7:0]  send_data_i = '0;
  logic [15:0] poll_limit_i = 16'd8;
  logic        busy_o, done_o, recv_end_o, err_timeout_o, err_bus_o;
  logic [7:0]  recv_data_o;
  logic        bus_req_o, bus_we_o;
  logic [7:0]  bus_addr_o;
  logic [15:0] bus_wdata_o;
  logic [15:0] bus_rdata_i = '0;
  logic        bus_ack_i = 0, bus_err_i = 0;

  wsc_commander dut_i (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // servant model
  logic [15:0] resp_q[$];
  logic [15:0] wr_log[$];
  logic [15:0] data_word = '0;
  int lat = 0, lat_cnt = 0, acc_n = 0, err_at = -1, resp_reads = 0;

  // reference model
  int m_ph = 0, m_fail = 0;
  bit m_dir, m_end, m_done, m_to, m_be, m_rend;
  logic [7:0] m_data, m_rx;

  always @(posedge clk_i or negedge rst_ni) begin
    int eff;
    bit ok;
    if (!rst_ni) begin
      m_ph = 0; m_fail = 0; m_done = 0; m_to = 0; m_be = 0; m_rx = 0; m_rend = 0;
      m_dir = 0; m_end = 0; m_data = 0;
    end else begin
      m_done = 0;
      eff = (poll_limit_i == 0) ? 1 : int'(poll_limit_i);
      if (m_ph == 0) begin
        if (send_req_i || recv_req_i) begin
          m_ph = 1; m_dir = send_req_i; m_data = send_data_i; m_end = send_end_i;
          m_to = 0; m_be = 0; m_fail = 0;
        end
      end else if (bus_err_i) begin
        m_be = 1; m_done = 1; m_ph = 0;
      end else if (bus_ack_i) begin
        if (m_ph == 1 || m_ph == 3) begin
          ok = (m_ph == 1) ? (bus_rdata_i[9] && (m_dir ? bus_rdata_i[12] : bus_rdata_i[13]))
                           : bus_rdata_i[10];
          if (ok) begin m_ph = m_ph + 1; m_fail = 0; end
          else if (m_fail + 1 >= eff) begin m_to = 1; m_done = 1; m_ph = 0; end
          else m_fail++;
        end else if (m_ph == 2) begin
          if (m_dir) begin m_done = 1; m_ph = 0; end else m_ph = 3;
        end else begin
          m_rx = bus_rdata_i[7:0]; m_rend = bus_rdata_i[8]; m_done = 1; m_ph = 0;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    logic [15:0] exp_wd;
    cyc++;
    if (rst_ni) begin
      chk(busy_o == (m_ph != 0), "R2 busy", busy_o, m_ph != 0);
      chk(done_o == m_done, "R10 done", done_o, m_done);
      chk(bus_req_o == (m_ph != 0), "R3 req", bus_req_o, m_ph != 0);
      chk(err_timeout_o == m_to, "R8 timeout flag", err_timeout_o, m_to);
      chk(err_bus_o == m_be, "R9 bus error flag", err_bus_o, m_be);
      chk(recv_data_o == m_rx && recv_end_o == m_rend, "R7 received byte",
          {recv_end_o, recv_data_o}, {m_rend, m_rx});
      if (m_ph != 0) begin
        chk(bus_addr_o == ((m_ph == 2 || m_ph == 4) ? 8'h0E : 8'h0A), "R4 addr",
            bus_addr_o, (m_ph == 2 || m_ph == 4) ? 8'h0E : 8'h0A);
        chk(bus_we_o == (m_ph == 2), "R6 we", bus_we_o, m_ph == 2);
        exp_wd = (m_ph != 2) ? 16'h0 : !m_dir ? 16'hDEFF : {(m_end ? 8'hBD : 8'hBC), m_data};
        chk(bus_wdata_o == exp_wd, "R5 wdata", bus_wdata_o, exp_wd);
      end
    end
    // servant
    if (bus_ack_i || bus_err_i) begin
      bus_ack_i = 0; bus_err_i = 0;
    end else if (rst_ni && bus_req_o) begin
      if (lat_cnt >= lat) begin
        lat_cnt = 0;
        if (acc_n == err_at) bus_err_i = 1;
        else begin
          bus_ack_i = 1;
          if (bus_we_o) wr_log.push_back(bus_wdata_o);
          else if (bus_addr_o == 8'h0A) begin
            resp_reads++;
            bus_rdata_i = (resp_q.size() > 0) ? resp_q.pop_front() : 16'h0;
          end else bus_rdata_i = data_word;
        end
        acc_n++;
      end else lat_cnt++;
    end
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic prep(int l, int e);
    resp_q.delete(); wr_log.delete();
    lat = l; lat_cnt = 0; acc_n = 0; err_at = e; resp_reads = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (!done_o);
  endtask

  task automatic send(logic [7:0] d, bit e);
    @(negedge clk_i);
    send_req_i = 1; send_data_i = d; send_end_i = e;
    @(negedge clk_i);
    send_req_i = 0;
    wait_done();
  endtask

  task automatic recv();
    @(negedge clk_i);
    recv_req_i = 1;
    @(negedge clk_i);
    recv_req_i = 0;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !bus_req_o && !done_o && !err_timeout_o && !err_bus_o,
        "R1 reset state", {busy_o, bus_req_o, done_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !bus_req_o, "R1 after release", busy_o, 0);

    // plain send, immediate ready
    prep(0, -1); resp_q.push_back(B_WR | B_DIR);
    send(8'h5A, 0);
    chk(wr_log.size() == 1 && wr_log[0] == 16'hBC5A, "R5 normal byte word",
        wr_log.size() ? wr_log[0] : 0, 16'hBC5A);

    // send with end, polls until both bits
    prep(2, -1);
    resp_q.push_back(0); resp_q.push_back(B_WR); resp_q.push_back(B_DIR | B_DOR);
    resp_q.push_back(B_WR | B_DIR);
    send(8'h3C, 1);
    chk(resp_reads == 4, "R4 status reads before write", resp_reads, 4);
    chk(wr_log.size() == 1 && wr_log[0] == 16'hBD3C, "R5 end byte word",
        wr_log.size() ? wr_log[0] : 0, 16'hBD3C);

    // receive, two poll phases
    prep(1, -1);
    resp_q.push_back(B_WR | B_DIR); resp_q.push_back(B_WR | B_DOR);
    resp_q.push_back(B_WR); resp_q.push_back(B_RR);
    data_word = 16'h00C3;
    recv();
    chk(wr_log.size() == 1 && wr_log[0] == 16'hDEFF, "R6 byte request",
        wr_log.size() ? wr_log[0] : 0, 16'hDEFF);
    chk(resp_reads == 4, "R7 second poll reads", resp_reads, 4);
    chk(recv_data_o == 8'hC3 && !recv_end_o, "R7 byte and end", {recv_end_o, recv_data_o}, 16'h0C3);

    // receive with end bit
    prep(0, -1); resp_q.push_back(B_WR | B_DOR); resp_q.push_back(B_RR);
    data_word = 16'hFF77;
    recv();
    chk(recv_data_o == 8'h77 && recv_end_o, "R7 end bit", {recv_end_o, recv_data_o}, 16'h177);

    // timeout in first phase
    prep(0, -1); poll_limit_i = 3;
    send(8'h11, 0);
    chk(err_timeout_o && !err_bus_o, "R8 timeout raised", err_timeout_o, 1);
    chk(resp_reads == 3 && wr_log.size() == 0, "R8 reads before abort", resp_reads, 3);
    repeat (5) @(negedge clk_i);
    chk(!bus_req_o && err_timeout_o, "R8 no access after abort", bus_req_o, 0);
    chk(recv_data_o == 8'h77, "R7 byte held", recv_data_o, 8'h77);

    // timeout in second phase of receive
    prep(0, -1); poll_limit_i = 2; resp_q.push_back(B_WR | B_DOR);
    recv();
    chk(err_timeout_o && wr_log.size() == 1 && resp_reads == 3, "R8 second phase",
        resp_reads, 3);

    // limit 0 behaves as 1
    prep(0, -1); poll_limit_i = 0;
    send(8'h22, 0);
    chk(err_timeout_o && resp_reads == 1, "R8 zero limit", resp_reads, 1);

    // bus error on the second access; flags cleared at accept
    prep(1, 1); poll_limit_i = 8;
    resp_q.push_back(0); resp_q.push_back(B_WR | B_DIR);
    send(8'h44, 0);
    chk(err_bus_o && !err_timeout_o && wr_log.size() == 0, "R9 bus error abort",
        {err_bus_o, err_timeout_o}, 2);
    repeat (4) @(negedge clk_i);
    chk(!bus_req_o, "R9 no access after error", bus_req_o, 0);

    // simultaneous requests and request while busy
    prep(1, -1); resp_q.push_back(0); resp_q.push_back(B_WR | B_DIR);
    @(negedge clk_i);
    send_req_i = 1; recv_req_i = 1; send_data_i = 8'h99; send_end_i = 0;
    @(negedge clk_i);
    send_req_i = 0; recv_req_i = 0;
    chk(!err_bus_o, "R10 flag cleared at accept", err_bus_o, 0);
    @(negedge clk_i);
    recv_req_i = 1;
    @(negedge clk_i);
    recv_req_i = 0;
    wait_done();
    repeat (6) @(negedge clk_i);
    chk(wr_log.size() == 1 && wr_log[0] == 16'hBC99, "R2 send wins tie",
        wr_log.size() ? wr_log[0] : 0, 16'hBC99);
    chk(!busy_o && resp_reads == 2, "R2 busy request ignored", resp_reads, 2);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule